// File: doc/BRIEF.md
# Thyristor Phase-Angle Soft-Start Sequencer

This block charges a DC bus capacitor from the AC mains through two thyristors. It does this gently, by moving their firing point forward a little more on each half-cycle. Every half-cycle is timed from a zero-crossing strobe. After a turn-on delay, the block fires the thyristor that matches the line polarity sampled with that strobe. It fires it with a train of gate pulses, not a single edge. The delay starts at a programmed maximum and shrinks by a fixed step on every new half-cycle. Once the next delay would fall below a programmed floor, or the subtraction would go negative, both gates are held on continuously and a charge-complete flag is raised.

The controller raises `start` and holds it while charging is wanted. Dropping `start`, or pulsing `abort`, turns both gates off and parks the sequencer. The five timing settings are sampled when the sequencer leaves idle, and they are frozen from then on. All delays, on-times and periods are counted in clock cycles.

The states are IDLE, ARMED, WAIT, FIRE and FULL. The transitions are as follows:
- IDLE goes to ARMED when `start` is high and `abort` is low. The settings are captured on this transition.
- ARMED goes to WAIT on a strobe, loading the maximum delay. It goes to FULL instead if the maximum is below the floor.
- WAIT goes to FIRE when the delay count is reached.
- WAIT or FIRE goes back to WAIT on a strobe, with the stepped-down delay. It goes to FULL instead when the stepped delay underflows or falls below the floor.
- FULL holds.
- Any state goes to IDLE on `abort`, or when `start` is low.

Top module: `scr_softstart_seq`

## Requirements
- R1: After reset, and in IDLE, `gate_pos`, `gate_neg` and `charge_done` are low, and strobes have no effect.
- R2: A strobe sampled on clock edge E0 in ARMED starts a half-cycle with delay `cfg_max_delay`. The matching gate first goes high after edge E0+D+1, where D is the delay.
- R3: A strobe with `line_pos`=1 makes the half-cycle drive `gate_pos`. A strobe with `line_pos`=0 makes it drive `gate_neg`. The other gate stays low, and both are never high together outside FULL.
- R4: Each later strobe sets the delay to the previous delay minus `cfg_step`.
- R5: From the firing point, the gate is high for the first `cfg_pulse_on` cycles of every `cfg_pulse_period` cycles. A period of 0 behaves as 1, and an on-time of at least the period gives continuous drive.
- R6: A strobe that arrives before the delay expires suppresses all pulses in that half-cycle. A strobe during a pulse train ends the train on the next edge.
- R7: At a strobe, if `cfg_step` exceeds the current delay, or if the new delay is below `cfg_min_delay`, the block enters FULL. In FULL both gates and `charge_done` stay high until it is stopped.
- R8: If `abort` is high, or `start` is low, on an edge, then after that edge both gates and `charge_done` are low and the state is IDLE. The block re-arms when `start` is high and `abort` is low.
- R9: The settings are captured only on the IDLE-to-ARMED transition. Port changes after that have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Hold high to run the soft-start |
| abort | input | 1 | Immediate stop request |
| zc_strobe | input | 1 | One-cycle zero-crossing strobe |
| line_pos | input | 1 | Line polarity for the half-cycle that is starting (1 = positive) |
| cfg_max_delay | input | 16 | Delay of the first half-cycle, in cycles |
| cfg_step | input | 16 | Delay decrement per half-cycle |
| cfg_min_delay | input | 16 | Floor below which full conduction begins |
| cfg_pulse_on | input | 16 | Gate pulse high time, in cycles |
| cfg_pulse_period | input | 16 | Gate pulse repetition period, in cycles |
| gate_pos | output | 1 | Gate drive, positive half-cycle thyristor |
| gate_neg | output | 1 | Gate drive, negative half-cycle thyristor |
| charge_done | output | 1 | High in continuous-conduction state |

## Verification
Every output is a function of registered state. A strobe or stop request sampled on an edge therefore shows up on the ports directly after that edge. A firing point shows up after edge E0+D+1, counted from the edge that sampled the strobe. The bench drives its inputs just after each rising edge. It keeps a behavioural model that applies the same edge rules to integer counters, and it compares all three outputs at every falling edge. Directed checks also sample the gate on the last cycle before the expected rise and on the first cycle after it, and they check the outputs on the cycle right after a stop request or a truncating strobe.

// File: rtl/scr_ss_pkg.sv
package scr_ss_pkg;
    typedef enum logic [2:0] {
        SS_IDLE  = 3'd0,
        SS_ARMED = 3'd1,
        SS_WAIT  = 3'd2,
        SS_FIRE  = 3'd3,
        SS_FULL  = 3'd4
    } ss_state_e;
endpackage

// File: rtl/scr_ss_step.sv
// Computes the delay for the half-cycle that begins at a zero crossing
// and decides whether phase control ends there.
module scr_ss_step #(
    parameter int W = 16
) (
    input  logic         first,
    input  logic [W-1:0] cur_delay,
    input  logic [W-1:0] max_delay,
    input  logic [W-1:0] step,
    input  logic [W-1:0] min_delay,
    output logic [W-1:0] next_delay,
    output logic         go_full
);
    logic [W:0] diff;
    logic       under;

    always_comb begin
        diff  = {1'b0, cur_delay} - {1'b0, step};
        under = diff[W];
        if (first) begin
            next_delay = max_delay;
        end else if (under) begin
            next_delay = '0;
        end else begin
            next_delay = diff[W-1:0];
        end
        go_full = (!first && under) || (next_delay < min_delay);
    end
endmodule

// File: rtl/scr_ss_pulse.sv
// Gate pulse train: high for on_time cycles out of every period cycles.
module scr_ss_pulse #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] on_time,
    input  logic [W-1:0] period,
    output logic         active
);
    logic [W-1:0] pcnt;
    logic [W:0]   inc;

    assign inc = {1'b0, pcnt} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run) begin
            pcnt <= '0;
        end else if (inc >= {1'b0, period}) begin
            pcnt <= '0;
        end else begin
            pcnt <= inc[W-1:0];
        end
    end

    assign active = run && (pcnt < on_time);

    p_quiet_when_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !active);
    p_train_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt == '0));
endmodule

// File: rtl/scr_softstart_seq.sv
module scr_softstart_seq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         zc_strobe,
    input  logic         line_pos,
    input  logic [W-1:0] cfg_max_delay,
    input  logic [W-1:0] cfg_step,
    input  logic [W-1:0] cfg_min_delay,
    input  logic [W-1:0] cfg_pulse_on,
    input  logic [W-1:0] cfg_pulse_period,
    output logic         gate_pos,
    output logic         gate_neg,
    output logic         charge_done
);
    import scr_ss_pkg::*;

    ss_state_e    state, nxt_state;
    logic [W-1:0] max_q, step_q, min_q, on_q, per_q;
    logic [W-1:0] cur_delay, cnt;
    logic         pol;
    logic         stop_req, launch, at_cross;
    logic [W-1:0] next_delay;
    logic         go_full;
    logic         pulse_act;

    assign stop_req = abort || !start;
    assign launch   = (state == SS_IDLE) && !stop_req;
    assign at_cross = zc_strobe && !stop_req &&
                      (state == SS_ARMED || state == SS_WAIT || state == SS_FIRE);

    scr_ss_step #(.W(W)) u_step (
        .first      (state == SS_ARMED),
        .cur_delay  (cur_delay),
        .max_delay  (max_q),
        .step       (step_q),
        .min_delay  (min_q),
        .next_delay (next_delay),
        .go_full    (go_full)
    );

    scr_ss_pulse #(.W(W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == SS_FIRE),
        .on_time (on_q),
        .period  (per_q),
        .active  (pulse_act)
    );

    // Next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            SS_IDLE:  if (!stop_req) nxt_state = SS_ARMED;
            SS_ARMED: if (zc_strobe) nxt_state = go_full ? SS_FULL : SS_WAIT;
            SS_WAIT: begin
                if (zc_strobe)              nxt_state = go_full ? SS_FULL : SS_WAIT;
                else if (cnt >= cur_delay)  nxt_state = SS_FIRE;
            end
            SS_FIRE:  if (zc_strobe) nxt_state = go_full ? SS_FULL : SS_WAIT;
            SS_FULL:  nxt_state = SS_FULL;
            default:  nxt_state = SS_IDLE;
        endcase
        if (stop_req) nxt_state = SS_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SS_IDLE;
        else        state <= nxt_state;
    end

    // Settings capture and half-cycle datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q     <= '0;
            step_q    <= '0;
            min_q     <= '0;
            on_q      <= '0;
            per_q     <= '0;
            cur_delay <= '0;
            cnt       <= '0;
            pol       <= 1'b0;
        end else begin
            if (launch) begin
                max_q  <= cfg_max_delay;
                step_q <= cfg_step;
                min_q  <= cfg_min_delay;
                on_q   <= cfg_pulse_on;
                per_q  <= cfg_pulse_period;
            end
            if (at_cross) begin
                cur_delay <= next_delay;
                pol       <= line_pos;
                cnt       <= '0;
            end else if (state == SS_WAIT && cnt < cur_delay) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        gate_pos    = 1'b0;
        gate_neg    = 1'b0;
        charge_done = 1'b0;
        unique case (state)
            SS_FULL: begin
                gate_pos    = 1'b1;
                gate_neg    = 1'b1;
                charge_done = 1'b1;
            end
            SS_FIRE: begin
                gate_pos = pol && pulse_act;
                gate_neg = !pol && pulse_act;
            end
            default: ;
        endcase
    end

    p_rail_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_pos && gate_neg) |-> charge_done);
    p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort || !start) |=> (!gate_pos && !gate_neg && !charge_done));
    p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_done && start && !abort) |=> charge_done);
    p_done_on_cross_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(charge_done) |-> $past(zc_strobe));
    p_no_gate_while_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_IDLE || state == SS_ARMED || state == SS_WAIT) |-> (!gate_pos && !gate_neg));
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SS_IDLE) |=> ($stable(max_q) && $stable(step_q) && $stable(min_q)));
    p_fire_from_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_FIRE && $past(state) != SS_FIRE) |-> $past(state) == SS_WAIT);
endmodule

// File: tb/scr_softstart_seq_test.sv
`timescale 1ns/1ps
module scr_softstart_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0, zc_strobe = 1'b0, line_pos = 1'b0;
    logic [15:0] cfg_max_delay = '0, cfg_step = '0, cfg_min_delay = '0;
    logic [15:0] cfg_pulse_on = '0, cfg_pulse_period = '0;
    logic        gate_pos, gate_neg, charge_done;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    scr_softstart_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .zc_strobe(zc_strobe), .line_pos(line_pos),
        .cfg_max_delay(cfg_max_delay), .cfg_step(cfg_step),
        .cfg_min_delay(cfg_min_delay), .cfg_pulse_on(cfg_pulse_on),
        .cfg_pulse_period(cfg_pulse_period),
        .gate_pos(gate_pos), .gate_neg(gate_neg), .charge_done(charge_done)
    );

    // Behavioural reference: 0 idle, 1 armed, 2 waiting, 3 firing, 4 full
    int m_ph, m_cur, m_elapsed, m_ft, m_pol;
    int k_max, k_step, k_min, k_on, k_per;

    task automatic new_half(input int nd, input bit under);
        if (under || nd < k_min) m_ph = 4;
        else begin
            m_cur = nd; m_pol = line_pos; m_elapsed = 0; m_ph = 2;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cur = 0; m_elapsed = 0; m_ft = 0; m_pol = 0;
            k_max = 0; k_step = 0; k_min = 0; k_on = 0; k_per = 1;
        end else if (abort || !start) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: begin
                    k_max = cfg_max_delay; k_step = cfg_step; k_min = cfg_min_delay;
                    k_on = cfg_pulse_on;
                    k_per = (cfg_pulse_period == 0) ? 1 : int'(cfg_pulse_period);
                    m_ph = 1;
                end
                1: if (zc_strobe) new_half(k_max, 1'b0);
                2, 3: begin
                    if (zc_strobe) new_half(m_cur - k_step, k_step > m_cur);
                    else if (m_ph == 2) begin
                        if (m_elapsed >= m_cur) begin m_ph = 3; m_ft = 0; end
                        else m_elapsed++;
                    end else m_ft++;
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit fire, ep, en, ed;
            fire = (m_ph == 3) && ((m_ft % k_per) < k_on);
            ep = (m_ph == 4) || (fire && m_pol == 1);
            en = (m_ph == 4) || (fire && m_pol == 0);
            ed = (m_ph == 4);
            checks++;
            if (gate_pos !== ep || gate_neg !== en || charge_done !== ed) begin
                errors++;
                $display("FAIL %s model compare at %0t: got pos/neg/done=%b%b%b expected %b%b%b",
                         cur_req, $time, gate_pos, gate_neg, charge_done, ep, en, ed);
            end
        end
    end

    task automatic check(input string req, input string what, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic zc(input bit p);
        zc_strobe = 1'b1; line_pos = p;
        tick(1);
        zc_strobe = 1'b0;
    endtask

    // Sample the gate on the last low cycle and on the first high cycle
    task automatic expect_rise(input string req, input int d, input bit p);
        repeat (d + 1) @(negedge clk);
        check(req, "gate low before firing", p ? gate_pos : gate_neg, 1'b0);
        @(negedge clk);
        check(req, "gate high at firing", p ? gate_pos : gate_neg, 1'b1);
        check(req, "opposite gate low", p ? gate_neg : gate_pos, 1'b0);
        @(posedge clk); #1;
    endtask

    task automatic set_cfg(input int mx, input int st, input int mn, input int on, input int per);
        cfg_max_delay = 16'(mx); cfg_step = 16'(st); cfg_min_delay = 16'(mn);
        cfg_pulse_on = 16'(on); cfg_pulse_period = 16'(per);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        cur_req = "R1";
        check("R1", "gate_pos after reset", gate_pos, 1'b0);
        check("R1", "charge_done after reset", charge_done, 1'b0);
        zc(1); tick(5);
        check("R1", "strobe while idle", gate_pos | gate_neg, 1'b0);

        // Scenario A: delays 20, 14, 8 then 2 < 5 -> full
        cur_req = "R2";
        set_cfg(20, 6, 5, 3, 5);
        start = 1'b1; tick(3);
        zc(1); expect_rise("R2", 20, 1'b1);
        cur_req = "R4"; tick(30);
        zc(0); expect_rise("R4", 14, 1'b0);
        cur_req = "R9";
        set_cfg(200, 1, 0, 9, 9);          // must be ignored while running
        tick(30);
        zc(1); expect_rise("R9", 8, 1'b1);
        cur_req = "R7"; tick(30);
        zc(0);
        @(negedge clk);
        check("R7", "charge_done after floor crossed", charge_done, 1'b1);
        check("R7", "both gates on", gate_pos & gate_neg, 1'b1);
        @(posedge clk); #1; tick(20);
        check("R7", "charge_done held", charge_done, 1'b1);

        // Abort and re-arm with scenario B settings
        cur_req = "R8";
        set_cfg(50, 15, 1, 10, 4);
        abort = 1'b1; tick(1);
        check("R8", "gates after abort", gate_pos | gate_neg, 1'b0);
        check("R8", "done after abort", charge_done, 1'b0);
        abort = 1'b0; tick(3);

        // Scenario B: 50 and 35 never fire in 30-cycle halves; 20 fires and is cut
        cur_req = "R6";
        zc(1); tick(29);
        check("R6", "no pulse when strobe precedes delay", gate_pos, 1'b0);
        zc(0); tick(29);
        check("R6", "no pulse second short half", gate_neg, 1'b0);
        cur_req = "R5";
        zc(1); tick(25);
        check("R5", "continuous drive with on >= period", gate_pos, 1'b1);
        tick(4);
        check("R5", "still driven before strobe", gate_pos, 1'b1);
        cur_req = "R6";
        zc(0);
        check("R6", "pulse truncated by strobe", gate_pos, 1'b0);
        tick(29);
        cur_req = "R7";
        zc(1);
        check("R7", "underflow enters full", charge_done, 1'b1);
        cur_req = "R8";
        start = 1'b0; tick(1);
        check("R8", "start low stops", gate_pos | gate_neg | charge_done, 1'b0);

        // Scenario C: delays 10, 0, then underflow; on 2 of period 3
        cur_req = "R5";
        set_cfg(10, 10, 0, 2, 3);
        start = 1'b1; tick(2);
        zc(1); expect_rise("R5", 10, 1'b1);
        tick(20);
        cur_req = "R4";
        zc(0); expect_rise("R4", 0, 1'b0);
        tick(10);
        cur_req = "R7";
        zc(1);
        check("R7", "step above delay enters full", charge_done, 1'b1);
        start = 1'b0; tick(3);
        finish_run();
    end
endmodule